// File: doc/BRIEF.md
# Banked Serial Register File

This block is a four-wire serial slave that lets a host controller write and read a bank of 10-bit control registers. Each access is one 16-bit frame sent most significant bit first while chip select is held low. The first bit selects read or write, the next five bits give an address and the last ten bits carry data. Five address bits reach only 32 locations, so bit 0 of main register 0 chooses whether an address refers to the main bank or to a second, local bank. Every stored register drives a parallel output bus so that control logic elsewhere on the chip can use it directly.

The serial pins are asynchronous to the chip clock. They are brought into the `clk_i` domain through two-stage synchronizers, and all edge detection runs in that domain. Write data lands in its register only when chip select is released, and only when the frame held exactly 16 bits. One main location is a readback-only status window: it never stores data, and a read returns the `status_i` input only while an enable bit in another main register is set. The register storage has no reset. Its contents are undefined until the host writes them, and `rst_ni` does not clear them.

Top module: `spi_rf_top`

## Requirements
- R1: A frame is shifted in MSB first on DIN, one bit per rising SCLK edge while CS is low. Bit 15 is the direction (1 = read, 0 = write), bits 14:10 are the address and bits 9:0 are the data. SCLK edges while CS is high are not counted.
- R2: A write frame changes storage only after CS rises. No register output changes while CS is low, even after all 16 bits have been shifted in.
- R3: A frame that holds fewer or more than 16 bits when CS rises writes nothing.
- R4: Bit 0 of main register 0 selects the bank for addresses 1 to 31: 0 selects the main bank and 1 selects the local bank. Address 0 always refers to main register 0. The local bank has no register at address 0, and its output slot 0 is zero.
- R5: In a read frame, the addressed register is driven on DOUT, D9 first. DOUT changes on falling SCLK edges, starting at the falling edge after the sixth bit, so the host samples D9..D0 on rising edges 7 to 16.
- R6: DOUT is low whenever CS is high and throughout a write frame.
- R7: Main address 21 is readback-only. Writes to it are ignored, and its slot on `main_regs_o` is zero. A read returns `status_i` when bit 9 of main register 27 is 1 and returns zero otherwise.
- R8: Register contents are not reset. They keep their values across an `rst_ni` pulse, and read frames never alter them.
- R9: Main register i appears on `main_regs_o[i*10 +: 10]` and local register i on `local_regs_o[i*10 +: 10]`. Between frames, both buses always match the values last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Chip clock used to oversample the serial pins |
| rst_ni | input | 1 | Active-low asynchronous reset of the frame logic only |
| sclk_i | input | 1 | Serial clock from the host |
| cs_ni | input | 1 | Active-low chip select that frames each access |
| din_i | input | 1 | Serial data from the host |
| dout_o | output | 1 | Serial read data to the host |
| status_i | input | 10 | Readback-only status value |
| main_regs_o | output | 320 | All main-bank registers, 10 bits each |
| local_regs_o | output | 320 | All local-bank registers, 10 bits each |

## Verification
The assertions rely on three properties of the host's stimulus:
- SCLK and CS never move in the same chip-clock window.
- Each SCLK phase lasts several chip clocks longer than the synchronizer latency.
- CS stays high long enough between frames for its rise to be seen.

The bench drives SCLK with a half period of eight chip clocks and changes DIN and CS only on the falling chip-clock edge, well apart from any SCLK edge, so every edge is detected exactly once. The assertions on stable storage and on the bank selector also assume that registers change only through frames. The bench gives the storage no other path.

// File: rtl/spi_rf_pkg.sv
package spi_rf_pkg;
  localparam int DATA_W   = 10;
  localparam int ADDR_W   = 5;
  localparam int HDR_W    = 1 + ADDR_W;
  localparam int FRAME_W  = HDR_W + DATA_W;
  localparam int NUM_REGS = 1 << ADDR_W;
  localparam int CNT_W    = $clog2(FRAME_W + 2);
  localparam int IDX_W    = $clog2(DATA_W);

  typedef struct packed {
    logic                rd;
    logic [ADDR_W-1:0]   addr;
  } hdr_t;
endpackage

// File: rtl/spi_rf_sync.sv
module spi_rf_sync #(
  parameter int           W       = 3,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] prev_o
);
  logic [W-1:0] pipe_q [STAGES];
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) pipe_q[s] <= RST_VAL;
      prev_q <= RST_VAL;
    end else begin
      pipe_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) pipe_q[s] <= pipe_q[s-1];
      prev_q <= pipe_q[STAGES-1];
    end
  end

  assign q_o    = pipe_q[STAGES-1];
  assign prev_o = prev_q;
endmodule

// File: rtl/spi_rf_shifter.sv
module spi_rf_shifter
  import spi_rf_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sclk_s_i,
  input  logic               sclk_p_i,
  input  logic               cs_s_i,
  input  logic               cs_p_i,
  input  logic               din_s_i,
  input  logic [DATA_W-1:0]  rd_data_i,
  output hdr_t               hdr_o,
  output logic [FRAME_W-1:0] frame_o,
  output logic               commit_o,
  output logic               cs_rise_o,
  output logic               dout_o
);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(FRAME_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_HDR  = CNT_W'(HDR_W);

  logic [CNT_W-1:0]   cnt_q;
  logic [FRAME_W-1:0] frame_q;
  hdr_t               hdr_q;
  logic               dout_q;
  logic               sclk_rise, sclk_fall;
  logic [CNT_W-1:0]   idx_full;
  logic [IDX_W-1:0]   idx;
  logic               in_data;

  assign sclk_rise = sclk_s_i & ~sclk_p_i;
  assign sclk_fall = ~sclk_s_i & sclk_p_i;
  assign cs_rise_o = cs_s_i & ~cs_p_i;
  // bit position of read data for the current count
  assign idx_full  = CNT_W'(FRAME_W - 1) - cnt_q;
  assign idx       = idx_full[IDX_W-1:0];
  assign in_data   = (cnt_q >= CNT_HDR) && (cnt_q < CNT_FULL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      frame_q <= '0;
      hdr_q   <= '0;
      dout_q  <= 1'b0;
    end else if (cs_s_i) begin
      cnt_q  <= '0;
      hdr_q  <= '0;
      dout_q <= 1'b0;
    end else begin
      if (sclk_rise) begin
        frame_q <= {frame_q[FRAME_W-2:0], din_s_i};
        if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CNT_HDR - 1'b1) hdr_q <= {frame_q[HDR_W-2:0], din_s_i};
      end
      if (sclk_fall) dout_q <= (hdr_q.rd && in_data) ? rd_data_i[idx] : 1'b0;
    end
  end

  assign commit_o = cs_rise_o && (cnt_q == CNT_FULL) && !frame_q[FRAME_W-1];
  assign hdr_o    = hdr_q;
  assign frame_o  = frame_q;
  assign dout_o   = dout_q;

  assert_dout_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_s_i && $past(cs_s_i)) |-> !dout_o);

  assert_dout_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_s_i && cnt_q >= CNT_HDR && !hdr_q.rd) |=> !dout_o);

  assert_cnt_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_MAX);
endmodule

// File: rtl/spi_rf_bank.sv
module spi_rf_bank #(
  parameter int N      = 32,
  parameter int DW     = 10,
  parameter int FIRST  = 0,
  parameter int RO_IDX = -1,
  localparam int AW    = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o,
  output logic [N*DW-1:0] regs_o
);
  for (genvar i = 0; i < N; i++) begin : g_reg
    if (i < FIRST || i == RO_IDX) begin : g_none
      assign regs_o[i*DW +: DW] = '0;
    end else begin : g_store
      logic [DW-1:0] q;
      // no reset: contents undefined until written
      always_ff @(posedge clk_i) begin
        if (we_i && waddr_i == AW'(i)) q <= wdata_i;
      end
      assign regs_o[i*DW +: DW] = q;
    end
  end

  assign rdata_o = regs_o[raddr_i*DW +: DW];
endmodule

// File: rtl/spi_rf_top.sv
module spi_rf_top
  import spi_rf_pkg::*;
#(
  parameter int RB_ADDR    = 21,
  parameter int RB_EN_ADDR = 27,
  parameter int RB_EN_BIT  = 9,
  parameter int SYNC_STG   = 2
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         sclk_i,
  input  logic                         cs_ni,
  input  logic                         din_i,
  output logic                         dout_o,
  input  logic [DATA_W-1:0]            status_i,
  output logic [NUM_REGS*DATA_W-1:0]   main_regs_o,
  output logic [NUM_REGS*DATA_W-1:0]   local_regs_o
);
  localparam logic [ADDR_W-1:0] RB_A = ADDR_W'(RB_ADDR);

  logic [2:0] pins_s, pins_p;
  logic sclk_s, sclk_p, cs_s, cs_p, din_s;

  spi_rf_sync #(.W(3), .STAGES(SYNC_STG), .RST_VAL(3'b010)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({din_i, cs_ni, sclk_i}),
    .q_o    (pins_s),
    .prev_o (pins_p)
  );

  assign {din_s, cs_s, sclk_s} = pins_s;
  assign sclk_p = pins_p[0];
  assign cs_p   = pins_p[1];

  hdr_t               hdr;
  logic [FRAME_W-1:0] frame;
  logic               commit, cs_rise;
  logic [DATA_W-1:0]  rd_data, main_rd, local_rd;

  spi_rf_shifter u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sclk_s_i  (sclk_s),
    .sclk_p_i  (sclk_p),
    .cs_s_i    (cs_s),
    .cs_p_i    (cs_p),
    .din_s_i   (din_s),
    .rd_data_i (rd_data),
    .hdr_o     (hdr),
    .frame_o   (frame),
    .commit_o  (commit),
    .cs_rise_o (cs_rise),
    .dout_o    (dout_o)
  );

  logic [ADDR_W-1:0] waddr;
  logic [DATA_W-1:0] wdata;
  logic              sel_local, rb_en, w_main, r_main;

  assign waddr     = frame[FRAME_W-2 -: ADDR_W];
  assign wdata     = frame[DATA_W-1:0];
  assign sel_local = main_regs_o[0];
  assign rb_en     = main_regs_o[RB_EN_ADDR*DATA_W + RB_EN_BIT];
  // address 0 always reaches main register 0 so the selector can be cleared
  assign w_main    = (waddr == '0) || !sel_local;
  assign r_main    = (hdr.addr == '0) || !sel_local;

  spi_rf_bank #(.N(NUM_REGS), .DW(DATA_W), .FIRST(0), .RO_IDX(RB_ADDR)) u_main (
    .clk_i   (clk_i),
    .we_i    (commit && w_main),
    .waddr_i (waddr),
    .wdata_i (wdata),
    .raddr_i (hdr.addr),
    .rdata_o (main_rd),
    .regs_o  (main_regs_o)
  );

  spi_rf_bank #(.N(NUM_REGS), .DW(DATA_W), .FIRST(1), .RO_IDX(-1)) u_local (
    .clk_i   (clk_i),
    .we_i    (commit && !w_main),
    .waddr_i (waddr),
    .wdata_i (wdata),
    .raddr_i (hdr.addr),
    .rdata_o (local_rd),
    .regs_o  (local_regs_o)
  );

  always_comb begin
    if (!r_main)              rd_data = local_rd;
    else if (hdr.addr == RB_A) rd_data = rb_en ? status_i : '0;
    else                      rd_data = main_rd;
  end

  assert_regs_stable_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_s |=> ($stable(main_regs_o) && $stable(local_regs_o)));

  assert_sel_change_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sel_local) |-> $past(cs_rise));
endmodule

// File: tb/spi_rf_top_tb_top.sv
`timescale 1ns/1ps
module spi_rf_top_tb_top;
  localparam int DW = 10, NR = 32, H = 8, RB = 21, RBE = 27;

  logic clk = 0, rst_n = 0, sclk = 0, cs_n = 1, din = 0;
  logic dout;
  logic [DW-1:0] status;
  logic [NR*DW-1:0] mregs, lregs;

  int n_tests = 0, n_fail = 0, cyc = 0, quiet = 0, mon_err = 0;
  bit done = 0;
  logic [DW-1:0] em [NR];
  logic [DW-1:0] el [NR];
  bit vm [NR];
  bit vl [NR];
  bit sel_m = 0;

  spi_rf_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .cs_ni(cs_n), .din_i(din),
    .dout_o(dout), .status_i(status), .main_regs_o(mregs), .local_regs_o(lregs)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] model_read(input int a);
    if (a == 0 || !sel_m) begin
      if (a == RB) return (vm[RBE] && em[RBE][9]) ? status : '0;
      return em[a];
    end
    return el[a];
  endfunction

  task automatic apply(input logic [31:0] w, input int n);
    int a;
    if (n != 16 || w[15]) return;
    a = int'(w[14:10]);
    if (a == 0 || !sel_m) begin
      if (a != RB) begin em[a] = w[9:0]; vm[a] = 1; end
      if (a == 0) sel_m = w[0];
    end else begin
      el[a] = w[9:0]; vl[a] = 1;
    end
  endtask

  task automatic shift(input logic [31:0] w, input int n, output logic [15:0] got, output bit nz);
    got = '0; nz = 0;
    for (int i = 0; i < n; i++) begin
      din = w[n-1-i];
      repeat (H) @(negedge clk);
      if (i >= 6 && i < 16) got[15-i] = dout;
      if (dout) nz = 1;
      sclk = 1;
      repeat (H) @(negedge clk);
      sclk = 0;
    end
    repeat (H) @(negedge clk);
  endtask

  task automatic xfer(input logic [31:0] w, input int n, output logic [15:0] got, output bit nz);
    @(negedge clk);
    cs_n = 0;
    repeat (H) @(negedge clk);
    shift(w, n, got, nz);
    cs_n = 1;
    apply(w, n);
    repeat (14) @(negedge clk);
  endtask

  function automatic logic [15:0] wr(input int a, input logic [DW-1:0] d);
    return {1'b0, 5'(a), d};
  endfunction

  task automatic do_write(input int a, input logic [DW-1:0] d);
    logic [15:0] g; bit nz;
    xfer({16'h0, wr(a, d)}, 16, g, nz);
    chk("R6 dout low in write frame", 32'(nz), 0);
  endtask

  task automatic do_read(input int a, input string req);
    logic [15:0] g; bit nz;
    xfer({16'h0, 1'b1, 5'(a), 10'h0}, 16, g, nz);
    chk(req, 32'(g[9:0]), 32'(model_read(a)));
  endtask

  // per-clock comparison of the register buses against the model between frames
  always @(negedge clk) begin
    cyc++;
    if (cs_n) quiet++; else quiet = 0;
    if (rst_n && quiet >= 10) begin
      for (int a = 0; a < NR; a++) begin
        if (vm[a] && mregs[a*DW +: DW] !== em[a]) mon_err++;
        if (vl[a] && lregs[a*DW +: DW] !== el[a]) mon_err++;
      end
      if (mregs[RB*DW +: DW] !== '0 || lregs[DW-1:0] !== '0) mon_err++;
      if (dout !== 1'b0) mon_err++;
    end
    if (cyc == 150000 && !done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] g; bit nz;
    status = 10'h1A5;
    repeat (5) @(negedge clk);
    chk("R6 dout low in reset", 32'(dout), 0);
    rst_n = 1;
    repeat (5) @(negedge clk);

    do_write(0, 10'h000);
    do_write(3, 10'h155);
    chk("R1 write main 3", 32'(mregs[3*DW +: DW]), 32'h155);
    chk("R9 main slot 0 bus", 32'(mregs[DW-1:0]), 0);
    do_read(3, "R5 read main 3");
    xfer({16'h0, 1'b1, 5'd3, 10'h3FF}, 16, g, nz);
    chk("R8 read frame leaves storage", 32'(mregs[3*DW +: DW]), 32'h155);

    do_write(0, 10'h001);
    do_write(3, 10'h2AA);
    chk("R4 local write lands in local bank", 32'(lregs[3*DW +: DW]), 32'h2AA);
    chk("R4 main 3 untouched by local write", 32'(mregs[3*DW +: DW]), 32'h155);
    do_read(3, "R4 read local 3");
    do_read(0, "R4 address 0 reaches main while local");
    chk("R4 local slot 0 is zero", 32'(lregs[DW-1:0]), 0);
    do_write(0, 10'h000);
    do_read(3, "R4 read main 3 after reselect");

    do_write(5, 10'h0F0);
    xfer({16'h0, wr(5, 10'h30F)} >> 1, 15, g, nz);
    chk("R3 15-bit frame dropped", 32'(mregs[5*DW +: DW]), 32'h0F0);
    xfer({15'h0, wr(5, 10'h30F), 1'b0}, 17, g, nz);
    chk("R3 17-bit frame dropped", 32'(mregs[5*DW +: DW]), 32'h0F0);
    do_write(5, 10'h30F);
    chk("R3 16-bit frame accepted", 32'(mregs[5*DW +: DW]), 32'h30F);

    do_write(RBE, 10'h000);
    do_write(RB, 10'h3FF);
    chk("R7 readback slot stays zero", 32'(mregs[RB*DW +: DW]), 0);
    do_read(RB, "R7 readback disabled gives zero");
    do_write(RBE, 10'h200);
    do_read(RB, "R7 readback shows status");
    status = 10'h05A;
    do_read(RB, "R7 readback follows status");

    do_write(7, 10'h111);
    @(negedge clk);
    cs_n = 0;
    repeat (H) @(negedge clk);
    shift({16'h0, wr(7, 10'h0AB)}, 16, g, nz);
    repeat (6) @(negedge clk);
    chk("R2 no commit before CS rises", 32'(mregs[7*DW +: DW]), 32'h111);
    cs_n = 1;
    apply({16'h0, wr(7, 10'h0AB)}, 16);
    repeat (14) @(negedge clk);
    chk("R2 commit after CS rises", 32'(mregs[7*DW +: DW]), 32'h0AB);

    for (int k = 0; k < 5; k++) begin
      din = k[0];
      repeat (H) @(negedge clk); sclk = 1;
      repeat (H) @(negedge clk); sclk = 0;
    end
    repeat (H) @(negedge clk);
    do_write(9, 10'h3C3);
    chk("R1 SCLK with CS high ignored", 32'(mregs[9*DW +: DW]), 32'h3C3);

    rst_n = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (12) @(negedge clk);
    chk("R8 main 3 kept over reset", 32'(mregs[3*DW +: DW]), 32'h155);
    chk("R8 local 3 kept over reset", 32'(lregs[3*DW +: DW]), 32'h2AA);
    do_read(3, "R8 read after reset");

    chk("R9 per-clock bus compare", 32'(mon_err), 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule